// File: doc/BRIEF.md
# Low-Level Wake Qualifier

This block watches an active-low external interrupt line while the main I/O clock is stopped in a deep sleep state. It runs entirely on a slow, free-running auxiliary oscillator clock, so a low level can be recognised in any sleep state. A low level counts only if consecutive samples on that slow clock all see it low. The default is two samples. Once the level qualifies, the block raises its wake request and then times a programmable start-up interval, also in slow-clock cycles.

When the interval ends, the line is sampled once more. If it is still low and the interrupt is still enabled, the interrupt request is raised alongside the wake request. If the level went away during start-up, the system still wakes, but no interrupt is produced. Both outputs stay set until the sleep indication drops, meaning the system has resumed. From then on the block is idle and both outputs are low.

Top module: `lwq_wake_qualifier`

## Requirements
- R1: After a synchronous reset, `wake` and `int_req` are both 0.
- R2: While `deep_sleep` is 0, `wake` and `int_req` stay 0 whatever `line_n` does. On the first clock edge that sees `deep_sleep` at 0, both outputs clear.
- R3: With `deep_sleep` and `irq_en` both 1, `wake` rises on the edge that takes the second consecutive low sample of `line_n`.
- R4: A high sample on `line_n` restarts the sample count, so isolated one-cycle lows never raise `wake`.
- R5: While `irq_en` is 0 and the block is waiting, low samples are not counted and `wake` stays 0. Counting starts afresh once `irq_en` returns to 1.
- R6: `startup_sel` gives the start-up length in slow-clock edges after the edge that raised `wake`: 00 = 4, 01 = 16, 10 = 64, 11 = 1024. On the last of those edges, `int_req` is set if `line_n` is 0 and `irq_en` is 1.
- R7: If `line_n` is 1 on that last start-up edge, `wake` stays 1 and `int_req` stays 0.
- R8: `startup_sel` is captured on the edge that raises `wake`. Changes to it during start-up do not alter the length.
- R9: Once set, `wake` and `int_req` each hold while `deep_sleep` remains 1, even if `line_n` returns high.
- R10: `int_req` is never 1 while `wake` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow free-running oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| line_n | input | 1 | External interrupt line, low level is the event |
| deep_sleep | input | 1 | 1 while the I/O clock is stopped in sleep |
| irq_en | input | 1 | Interrupt enable for this line |
| startup_sel | input | 2 | Start-up length select |
| wake | output | 1 | Wake request to the clock controller |
| int_req | output | 1 | Level interrupt request |

## Verification
Two events can fall on the same edge: the start-up timer expiring, and the line changing level. The bench provokes this by releasing the line exactly on the final start-up edge, and separately by holding it low there. In the first case it expects `wake` to stay set with no interrupt; in the second it expects both outputs set. A second same-edge case is a write to `startup_sel` just after `wake` rises. It is judged by the interrupt still appearing after the originally selected length.

// File: rtl/lwq_pkg.sv
package lwq_pkg;

    typedef enum logic [1:0] {
        ST_WATCH   = 2'd0,
        ST_STARTUP = 2'd1,
        ST_WOKEN   = 2'd2
    } lwq_state_e;

    typedef struct packed {
        logic watching;
        logic timing;
        logic wake;
        logic int_req;
    } lwq_ctl_t;

    function automatic int unsigned lwq_pick_len(
        input logic [1:0]  sel,
        input int unsigned l0,
        input int unsigned l1,
        input int unsigned l2,
        input int unsigned l3
    );
        case (sel)
            2'd0:    return l0;
            2'd1:    return l1;
            2'd2:    return l2;
            default: return l3;
        endcase
    endfunction

    function automatic int unsigned lwq_max4(
        input int unsigned a,
        input int unsigned b,
        input int unsigned c,
        input int unsigned d
    );
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/lwq_sampler.sv
module lwq_sampler #(
    parameter int unsigned QUAL_SAMPLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sample_en,
    input  logic line_n,
    output logic qualified
);
    localparam int unsigned CW = (QUAL_SAMPLES > 1) ? $clog2(QUAL_SAMPLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(QUAL_SAMPLES - 1);

    logic [CW-1:0] low_cnt;

    // Consecutive-low counter; any high sample or disable restarts it.
    always_ff @(posedge clk) begin
        if (rst || !sample_en || line_n) begin
            low_cnt <= '0;
        end else if (low_cnt != LAST) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign qualified = sample_en && !line_n && (low_cnt == LAST);

endmodule

// File: rtl/lwq_startup_timer.sv
module lwq_startup_timer #(
    parameter int unsigned TMR_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [TMR_W-1:0] len_m1,
    output logic             done
);
    logic [TMR_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != len_m1) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && (cnt == len_m1);

endmodule

// File: rtl/lwq_ctrl.sv
module lwq_ctrl
    import lwq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     deep_sleep,
    input  logic     irq_en,
    input  logic     line_n,
    input  logic     qualified,
    input  logic     tmr_done,
    output lwq_ctl_t ctl
);
    lwq_state_e state_q, state_d;
    logic       int_q, int_d;

    always_comb begin
        state_d = state_q;
        int_d   = int_q;
        case (state_q)
            ST_WATCH: begin
                if (qualified) state_d = ST_STARTUP;
            end
            ST_STARTUP: begin
                if (tmr_done) begin
                    state_d = ST_WOKEN;
                    int_d   = !line_n && irq_en;
                end
            end
            ST_WOKEN: state_d = ST_WOKEN;
            default:  state_d = ST_WATCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !deep_sleep) begin
            state_q <= ST_WATCH;
            int_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            int_q   <= int_d;
        end
    end

    always_comb begin
        ctl.watching = (state_q == ST_WATCH) && deep_sleep && irq_en;
        ctl.timing   = (state_q == ST_STARTUP);
        ctl.wake     = (state_q != ST_WATCH);
        ctl.int_req  = int_q;
    end

endmodule

// File: rtl/lwq_wake_qualifier.sv
module lwq_wake_qualifier
    import lwq_pkg::*;
#(
    parameter int unsigned QUAL_SAMPLES = 2,
    parameter int unsigned LEN_SEL0     = 4,
    parameter int unsigned LEN_SEL1     = 16,
    parameter int unsigned LEN_SEL2     = 64,
    parameter int unsigned LEN_SEL3     = 1024
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_n,
    input  logic       deep_sleep,
    input  logic       irq_en,
    input  logic [1:0] startup_sel,
    output logic       wake,
    output logic       int_req
);
    localparam int unsigned LEN_MAX = lwq_max4(LEN_SEL0, LEN_SEL1, LEN_SEL2, LEN_SEL3);
    localparam int unsigned TMR_W   = (LEN_MAX > 1) ? $clog2(LEN_MAX) : 1;

    lwq_ctl_t         ctl;
    logic             qualified;
    logic             tmr_done;
    logic [1:0]       sel_q;
    logic [TMR_W-1:0] len_m1;

    // Select follows the input while waiting and freezes once wake is up.
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (!ctl.wake) begin
            sel_q <= startup_sel;
        end
    end

    assign len_m1 = TMR_W'(lwq_pick_len(sel_q, LEN_SEL0, LEN_SEL1, LEN_SEL2, LEN_SEL3) - 1);

    lwq_sampler #(.QUAL_SAMPLES(QUAL_SAMPLES)) u_sampler (
        .clk       (clk),
        .rst       (rst),
        .sample_en (ctl.watching),
        .line_n    (line_n),
        .qualified (qualified)
    );

    lwq_startup_timer #(.TMR_W(TMR_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (ctl.timing),
        .len_m1 (len_m1),
        .done   (tmr_done)
    );

    lwq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .deep_sleep (deep_sleep),
        .irq_en     (irq_en),
        .line_n     (line_n),
        .qualified  (qualified),
        .tmr_done   (tmr_done),
        .ctl        (ctl)
    );

    assign wake    = ctl.wake;
    assign int_req = ctl.int_req;

endmodule

// File: rtl/lwq_wake_qualifier_chk.sv
module lwq_wake_qualifier_chk
    import lwq_pkg::*;
#(
    parameter int unsigned LEN_SEL0 = 4,
    parameter int unsigned LEN_SEL1 = 16,
    parameter int unsigned LEN_SEL2 = 64,
    parameter int unsigned LEN_SEL3 = 1024
) (
    input logic       clk,
    input logic       rst,
    input logic       line_n,
    input logic       deep_sleep,
    input logic       irq_en,
    input logic [1:0] startup_sel,
    input logic       wake,
    input logic       int_req
);
    int unsigned since_wake;
    int unsigned len_q;

    always_ff @(posedge clk) begin
        if (rst || !deep_sleep) since_wake <= 0;
        else if (wake)          since_wake <= since_wake + 1;
    end

    always_ff @(posedge clk) begin
        if (rst)        len_q <= LEN_SEL0;
        else if (!wake) len_q <= lwq_pick_len(startup_sel, LEN_SEL0, LEN_SEL1, LEN_SEL2, LEN_SEL3);
    end

    assert_int_needs_wake_R10: assert property (@(posedge clk) disable iff (rst)
        int_req |-> wake);

    assert_awake_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !deep_sleep |=> (!wake && !int_req));

    assert_wake_two_lows_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(wake) |-> ($past(!line_n) && $past(!line_n, 2) && $past(irq_en) && $past(deep_sleep)));

    assert_wake_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (wake && deep_sleep) |=> wake);

    assert_int_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (int_req && deep_sleep) |=> int_req);

    assert_int_needs_level_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(int_req) |-> ($past(!line_n) && $past(irq_en)));

    assert_startup_length_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(int_req) |-> (since_wake == len_q));

endmodule

bind lwq_wake_qualifier lwq_wake_qualifier_chk #(
    .LEN_SEL0 (LEN_SEL0),
    .LEN_SEL1 (LEN_SEL1),
    .LEN_SEL2 (LEN_SEL2),
    .LEN_SEL3 (LEN_SEL3)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .line_n      (line_n),
    .deep_sleep  (deep_sleep),
    .irq_en      (irq_en),
    .startup_sel (startup_sel),
    .wake        (wake),
    .int_req     (int_req)
);

// File: tb/lwq_wake_qualifier_tb.sv
module lwq_wake_qualifier_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_n = 1'b1;
    logic       deep_sleep = 1'b0;
    logic       irq_en = 1'b0;
    logic [1:0] startup_sel = 2'd0;
    logic       wake;
    logic       int_req;

    int vectors = 0;
    int fails   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lwq_wake_qualifier u_dut (
        .clk         (clk),
        .rst         (rst),
        .line_n      (line_n),
        .deep_sleep  (deep_sleep),
        .irq_en      (irq_en),
        .startup_sel (startup_sel),
        .wake        (wake),
        .int_req     (int_req)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic go_awake();
        deep_sleep = 1'b0; line_n = 1'b1; irq_en = 1'b0; startup_sel = 2'd0;
        tick(2);
    endtask

    // Enter sleep, pull line low, confirm wake edge timing (R3).
    task automatic sleep_and_qualify(input logic [1:0] sel);
        deep_sleep = 1'b1; irq_en = 1'b1; startup_sel = sel; line_n = 1'b1;
        tick(1);
        line_n = 1'b0;
        tick(1);
        check("R3 one low sample", wake, 1'b0);
        tick(1);
        check("R3 second low sample", wake, 1'b1);
        check("R10 no int at wake", int_req, 1'b0);
    endtask

    task automatic test_reset();
        tick(1);
        check("R1 wake after reset", wake, 1'b0);
        check("R1 int after reset", int_req, 1'b0);
        rst = 1'b0;
        tick(1);
    endtask

    task automatic test_awake_ignored();
        go_awake();
        irq_en = 1'b1; line_n = 1'b0;
        tick(6);
        check("R2 wake while awake", wake, 1'b0);
        check("R2 int while awake", int_req, 1'b0);
    endtask

    task automatic test_short_start();
        go_awake();
        sleep_and_qualify(2'd0);
        tick(3);
        check("R6 sel0 before end", int_req, 1'b0);
        tick(1);
        check("R6 sel0 at end", int_req, 1'b1);
        line_n = 1'b1;
        tick(3);
        check("R9 int held", int_req, 1'b1);
        check("R9 wake held", wake, 1'b1);
        deep_sleep = 1'b0;
        tick(1);
        check("R2 wake cleared on resume", wake, 1'b0);
        check("R2 int cleared on resume", int_req, 1'b0);
    endtask

    task automatic test_level_gone();
        go_awake();
        sleep_and_qualify(2'd1);
        tick(15);
        check("R6 sel1 before end", int_req, 1'b0);
        line_n = 1'b1;
        tick(1);
        check("R7 no int when level gone", int_req, 1'b0);
        check("R7 still woken", wake, 1'b1);
        tick(4);
        check("R9 wake held without int", wake, 1'b1);
        check("R7 int stays low", int_req, 1'b0);
    endtask

    task automatic test_glitch();
        go_awake();
        deep_sleep = 1'b1; irq_en = 1'b1; line_n = 1'b1;
        tick(1);
        for (int i = 0; i < 6; i++) begin
            line_n = 1'b0; tick(1);
            line_n = 1'b1; tick(1);
        end
        check("R4 isolated lows ignored", wake, 1'b0);
    endtask

    task automatic test_enable_low();
        go_awake();
        deep_sleep = 1'b1; irq_en = 1'b0; line_n = 1'b0;
        tick(5);
        check("R5 disabled no wake", wake, 1'b0);
        irq_en = 1'b1;
        tick(1);
        check("R5 count restarts", wake, 1'b0);
        tick(1);
        check("R5 wake after re-enable", wake, 1'b1);
    endtask

    task automatic test_sel_latched();
        go_awake();
        sleep_and_qualify(2'd0);
        startup_sel = 2'd3;
        tick(3);
        check("R8 before latched end", int_req, 1'b0);
        tick(1);
        check("R8 latched length used", int_req, 1'b1);
    endtask

    task automatic test_long(input logic [1:0] sel, input int len);
        go_awake();
        sleep_and_qualify(sel);
        tick(len - 1);
        check("R6 long before end", int_req, 1'b0);
        tick(1);
        check("R6 long at end", int_req, 1'b1);
    endtask

    task automatic test_enable_dropped();
        go_awake();
        sleep_and_qualify(2'd0);
        irq_en = 1'b0;
        tick(4);
        check("R6 no int when disabled at end", int_req, 1'b0);
        check("R6 wake kept", wake, 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        test_reset();
        test_awake_ignored();
        test_short_start();
        test_level_gone();
        test_glitch();
        test_enable_low();
        test_sel_latched();
        test_long(2'd2, 64);
        test_long(2'd3, 1024);
        test_enable_dropped();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule